// File: doc/BRIEF.md
# Port Edge Interrupt Unit

This block watches the eight input pins of one I/O port and raises a single interrupt request that belongs to that port alone. Each pin is first brought into the clock domain through a two-stage synchronizer. The unit then looks for level changes on the synchronized value. A per-pin mode decides which changes count: none, rising only, falling only, or both directions.

A matching change sets that pin's bit in a sticky status register. The interrupt request stays high for as long as any status bit is set. Firmware finds out which pins fired by reading the status register over a small register bus. That read returns the bits and empties the register in the same clock edge. An edge that lands on the very edge of a clearing read is kept, so no event is lost.

The per-pin modes sit in a second register on the same bus and can be read back. The external active-low reset clears the unit at once. Its release is passed through two flops, so the unit leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `pin_irq_port`

## Requirements
- R1: The mode register at bus address 0 holds one 2-bit field per pin, with pin i at bits [2i+1:2i]. The codes are 00 off, 01 rising edge only, 10 falling edge only and 11 both edges. A pin in code 00 never sets its status bit.
- R2: A synchronized 0-to-1 change on pin i sets status bit i when its code is 01 or 11. A 1-to-0 change sets it when its code is 10 or 11. An edge on one pin affects no other pin's bit.
- R3: Status bits are sticky. Once set, a bit stays set until a clearing read. Edges on several pins, whether together or at different times, accumulate.
- R4: A read (`rd_en`=1) at address 1 returns the status in `rdata[7:0]` with zeros above, in the same cycle. That read clears the status at the next rising edge. A qualifying edge that reaches the status in that same edge is kept.
- R5: `irq` is high exactly while at least one status bit is set.
- R6: A pin change applied between clock edges shows in the status and on `irq` after the third rising edge that follows it, and not after the second.
- R7: Address 0 reads back the mode register. A write to any other address changes nothing. A read of address 2 or 3 returns zero and clears nothing.
- R8: Writing a new mode while the pins are steady sets no status bit.
- R9: After reset, the status is 0, all modes are 00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| pins | input | 8 | Port pin levels, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read at address 1 clears the status |
| addr | input | 2 | Register address: 0 mode, 1 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational, zero when `rd_en` is low |
| irq | output | 1 | Port interrupt request |

## Verification
A pin change made at a falling clock edge passes through the two synchronizer flops and then reaches the status flop. Its effect is therefore due after the third rising edge. The bench waits exactly three falling edges before it samples `irq` or reads the status. In one directed case it also checks that nothing has shown after two. Read data is combinational, so it is sampled one time unit after the strobe is applied, before the clearing edge. The empty status is then confirmed on the next falling edge. For the coincident-edge case, the read is placed in the cycle between the second and third rising edges after the pin toggle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int MODE_W    = 2;
  localparam int ADDR_MODE = 0;
  localparam int ADDR_STAT = 1;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        lvl,
  input  logic [MODE_W*NPINS-1:0] mode,
  output logic [NPINS-1:0]        trig
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    edge_mode_e pm;
    logic       rise, fall;
    assign pm   = edge_mode_e'(mode[MODE_W*i +: MODE_W]);
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];
    always_comb begin
      unique case (pm)
        EDGE_RISE: trig[i] = rise;
        EDGE_FALL: trig[i] = fall;
        EDGE_BOTH: trig[i] = rise | fall;
        default:   trig[i] = 1'b0;
      endcase
    end

    // R1: a disabled pin never triggers
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pm == EDGE_OFF) |-> !trig[i]);
    // R2: a trigger in rising-only mode follows a low level in the previous cycle
    p_rise_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && pm == EDGE_RISE) |-> (lvl[i] && !$past(lvl[i])));
  end
endmodule

// File: rtl/status_latch.sv
module status_latch #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] trig,
  input  logic             clr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] stat_d;

  always_comb begin
    if (clr) stat_d = trig;
    else     stat_d = status | trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= stat_d;
  end

  // R3: without a clearing read no bit ever drops
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(status) & ~status) == '0));
  // R4: after a clearing read only the coincident triggers survive
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status == $past(trig)));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 2,
  localparam int DATA_W = MODE_W * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  status,
  output logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] rdata,
  output logic              clr
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic              mode_we;
  logic [DATA_W-1:0] mode_d;

  assign mode_we = wr_en && (addr == A_MODE);

  always_comb begin
    mode_d = mode;
    if (mode_we) mode_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else        mode <= mode_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_MODE)      rdata = mode;
      else if (addr == A_STAT) rdata = DATA_W'(status);
    end
  end

  assign clr = rd_en && (addr == A_STAT);

  // R7: the mode register moves only on a write to its own address
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_MODE) |=> $stable(mode));
endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  localparam int DATA_W     = MODE_W * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [NPINS-1:0]  lvl;
  logic [NPINS-1:0]  trig;
  logic [NPINS-1:0]  status;
  logic [DATA_W-1:0] mode;
  logic              clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .din(pins), .dout(lvl));

  edge_detect #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .lvl(lvl), .mode(mode), .trig(trig));

  status_latch #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_core_n), .trig(trig), .clr(clr), .status(status));

  cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status), .mode(mode), .rdata(rdata), .clr(clr));

  assign irq = |status;

  // R5: the request can only rise after some pin triggered
  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq) |-> $past(|trig));
  // R9: while held in reset the request is low
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_core_n |-> !irq);
endmodule

// File: tb/test_pin_irq_port.sv
module test_pin_irq_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_port i_pin_irq_port (
    .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WATCHDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d", cyc_cnt, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic bit fires(input logic [1:0] m, input bit rising);
    return (m == 2'b11) || (rising && m == 2'b01) || (!rising && m == 2'b10);
  endfunction

  initial begin
    logic [15:0] v;
    logic [15:0] mv;
    logic [7:0]  base;
    logic [7:0]  exp_s;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R9: reset state
    check(irq == 1'b0, "R9 irq", {15'd0, irq}, 16'd0);
    bus_rd(2'd0, v); check(v == 16'd0, "R9 mode", v, 16'd0);
    bus_rd(2'd1, v); check(v == 16'd0, "R9 status", v, 16'd0);

    // R1/R2: sweep pin x mode x direction; other pins in both-edge mode stay quiet
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 2; d++) begin
          mv = 16'hFFFF;
          mv[2*p +: 2] = 2'(m);
          base = 8'hA5;
          base[p] = (d == 1) ? 1'b0 : 1'b1;
          pins = base;
          bus_wr(2'd0, mv);
          cyc(4);
          bus_rd(2'd1, v);
          pins = base ^ (8'd1 << p);
          cyc(3);
          exp_s = fires(2'(m), d == 1) ? (8'd1 << p) : 8'd0;
          check(irq == (exp_s != 0), "R5 irq in sweep", {15'd0, irq}, {15'd0, exp_s != 0});
          bus_rd(2'd1, v);
          check(v == {8'd0, exp_s}, (m == 0) ? "R1 off pin" : "R2 edge mode", v, {8'd0, exp_s});
        end
      end
    end
    cyc(1);
    bus_rd(2'd1, v);
    check(v == 16'd0, "R4 cleared after read", v, 16'd0);
    check(irq == 1'b0, "R5 irq low when empty", {15'd0, irq}, 16'd0);

    // R3: all toggle masks with both-edge mode
    bus_wr(2'd0, 16'hFFFF);
    for (int k = 1; k < 256; k++) begin
      pins = pins ^ 8'(k);
      cyc(3);
      bus_rd(2'd1, v);
      check(v == 16'(k), "R3 multi-pin status", v, 16'(k));
    end

    // R3: accumulation over time
    pins = pins ^ 8'h01; cyc(4);
    pins = pins ^ 8'h80; cyc(4);
    bus_rd(2'd1, v);
    check(v == 16'h0081, "R3 accumulate", v, 16'h0081);

    // R6: latency exactly three rising edges
    pins = pins ^ 8'h10;
    cyc(2);
    check(irq == 1'b0, "R6 not after second edge", {15'd0, irq}, 16'd0);
    cyc(1);
    check(irq == 1'b1, "R6 after third edge", {15'd0, irq}, 16'd1);
    bus_rd(2'd1, v);

    // R4: edge coincident with clearing read is kept
    pins = pins ^ 8'h02; cyc(4);
    pins = pins ^ 8'h04;
    cyc(2);
    bus_rd(2'd1, v);
    check(v == 16'h0002, "R4 read data", v, 16'h0002);
    bus_rd(2'd1, v);
    check(v == 16'h0004, "R4 coincident edge kept", v, 16'h0004);

    // R7: readback, ignored write, unused address
    bus_wr(2'd0, 16'h1B6C);
    bus_rd(2'd0, v);
    check(v == 16'h1B6C, "R7 mode readback", v, 16'h1B6C);
    bus_wr(2'd0, 16'hFFFF);
    pins = pins ^ 8'h20; cyc(4);
    bus_wr(2'd1, 16'h0000);
    bus_wr(2'd2, 16'h0000);
    bus_rd(2'd0, v);
    check(v == 16'hFFFF, "R7 mode untouched", v, 16'hFFFF);
    bus_rd(2'd2, v);
    check(v == 16'd0, "R7 unused reads zero", v, 16'd0);
    check(irq == 1'b1, "R7 write to status ignored", {15'd0, irq}, 16'd1);
    bus_rd(2'd1, v);
    check(v == 16'h0020, "R7 status kept", v, 16'h0020);

    // R8: mode change with steady pins
    bus_wr(2'd0, 16'h0000);
    pins = 8'hFF; cyc(5);
    bus_rd(2'd1, v);
    bus_wr(2'd0, 16'h5555);
    cyc(5);
    check(irq == 1'b0, "R8 no trigger rising", {15'd0, irq}, 16'd0);
    pins = 8'h00; cyc(5);
    bus_rd(2'd1, v);
    check(v == 16'd0, "R8 falling ignored in rise mode", v, 16'd0);
    bus_wr(2'd0, 16'hAAAA);
    cyc(5);
    bus_rd(2'd1, v);
    check(v == 16'd0, "R8 no trigger falling", v, 16'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule